// File: doc/BRIEF.md
# Back-EMF Step Detection Sequencer

This block runs the monitoring window that follows each supervised drive pulse of a bipolar stepping motor. When a start strobe arrives, it first shorts the coil through both high-side switches for one time unit. It then opens every drive switch for a second unit so that the energy stored in the coil decays quickly. After that it enters a sensing phase. In the sensing phase, short sample strobes route the induced coil current through one sense switch paired with the opposite high-side switch. The pairings alternate from strobe to strobe, and their order swaps with the drive direction that was latched at start.

Two comparator flags come back from the analog side: one for a positive level exceeded and one for a negative level exceeded. A strobe with a positive flag arms a timer. A negative flag seen while that timer is still inside the programmed limit marks the step as taken. At the end of the window the block raises a one-cycle done strobe and holds the pass/fail result until the next window ends. All timing is counted in ticks of a clock enable; one time unit is `UNIT_TICKS` ticks. The default parameters assume a tick of about 61 µs, which gives units of 0.98 ms, strobes every 0.49 ms and a 27.3 ms window measured from the strobe.

Top module: `bemf_step_sequencer`

## Requirements
- R1: After reset, all six switch enables, the sample strobe, the done strobe and the result are low, and the block waits for a start.
- R2: A start accepted while idle closes both high-side switches (and no other switch) for `UNIT_TICKS` ticks.
- R3: The next `UNIT_TICKS` ticks open all four drive switches and both sense switches.
- R4: The sensing phase lasts `WINDOW_TICKS - 2*UNIT_TICKS` ticks. The sample strobe is high for one tick on the first tick and on every `STROBE_PERIOD`-th tick after it. Sense switches close only while the strobe is high, and both high-side switches stay closed between strobes.
- R5: With direction 0, the even-numbered strobes (counting from 0) close sense A with high-side B, and the odd-numbered strobes close high-side A with sense B. Direction 1 swaps the two pairings. Both sense switches are never closed at once.
- R6: The result is pass when a negative flag is seen at a strobe no more than L = (`LIMIT_BASE_UNITS` + code) × `UNIT_TICKS` ticks after the strobe that armed the timer. The 3-bit limit code is latched at start, and the default L runs from 64 to 176 ticks.
- R7: A negative flag is ignored while the timer is not armed. A positive flag does not restart a running timer. When L ticks pass without a qualifying negative flag, the timer disarms; a positive flag at that same strobe re-arms it from that strobe.
- R8: The done strobe is high for exactly one clock, in the clock after the final sensing tick. The result takes its new value in that same clock and holds it until the next done.
- R9: A start seen while a window is running has no effect, and the low-side drive switches are never closed by this block.
- R10: A window that ends without a qualifying positive-then-negative pair reports fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base clock enable, one tick per assertion |
| dir_i | input | 1 | Drive direction of the pulse just applied, latched at start |
| start_i | input | 1 | Begins a detection window when idle |
| limit_code_i | input | 3 | Time-limit code, latched at start |
| cmp_pos_i | input | 1 | Positive detection level exceeded |
| cmp_neg_i | input | 1 | Negative detection level exceeded |
| hs_a_o | output | 1 | High-side switch enable, coil end A |
| hs_b_o | output | 1 | High-side switch enable, coil end B |
| ls_a_o | output | 1 | Low-side switch enable, coil end A |
| ls_b_o | output | 1 | Low-side switch enable, coil end B |
| sns_a_o | output | 1 | Sense switch enable, coil end A |
| sns_b_o | output | 1 | Sense switch enable, coil end B |
| strobe_o | output | 1 | Sample strobe |
| done_o | output | 1 | One-cycle end-of-window strobe |
| pass_o | output | 1 | Step result, 1 = step taken |

## Verification
The bound checker watches switch safety on every cycle: the two sense switches never close together, each sense switch closes only with the opposite high side, sensing happens only under the strobe, and a shorted coil carries no sense path. It also checks that done lasts a single cycle and that the result changes only with done. Phase durations, the alternation order under each direction, the exact limit boundary, the ignoring of an early negative flag, the non-restarting timer, re-arming at expiry and the ignored mid-window start all depend on counted time and chosen stimulus. Only the bench's scenarios, compared cycle by cycle against its behavioural model, can show those.

// File: rtl/bemf_pkg.sv
package bemf_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SHORT = 2'd1,
      PH_FLOAT = 2'd2,
      PH_SENSE = 2'd3
   } bemf_phase_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/bemf_phase_timer.sv
module bemf_phase_timer
   import bemf_pkg::*;
#(
   parameter int unsigned UNIT_TICKS    = 16,
   parameter int unsigned STROBE_PERIOD = 8,
   parameter int unsigned WINDOW_TICKS  = 448
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        tick_i,
   input  logic        start_i,
   output bemf_phase_e phase_o,
   output logic        strobe_o,
   output logic        slot_odd_o,
   output logic        accept_o,
   output logic        last_o
);

   localparam int unsigned SENSE_TICKS = WINDOW_TICKS - 2 * UNIT_TICKS;
   localparam int unsigned CNT_MAX     = max2(UNIT_TICKS, SENSE_TICKS);
   localparam int unsigned CNT_W       = $clog2(CNT_MAX);
   localparam int unsigned SLOT_W      = (STROBE_PERIOD > 1) ? $clog2(STROBE_PERIOD) : 1;
   localparam logic [CNT_W-1:0] UNIT_LAST  = CNT_W'(UNIT_TICKS - 1);
   localparam logic [CNT_W-1:0] SENSE_LAST = CNT_W'(SENSE_TICKS - 1);

   bemf_phase_e      phase_q;
   logic [CNT_W-1:0] cnt_q;

   assign accept_o = (phase_q == PH_IDLE) && start_i;
   assign last_o   = (phase_q == PH_SENSE) && tick_i && (cnt_q == SENSE_LAST);
   assign phase_o  = phase_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  phase_q <= PH_SHORT;
                  cnt_q   <= '0;
               end
            end
            PH_SHORT: begin
               if (tick_i) begin
                  if (cnt_q == UNIT_LAST) begin
                     phase_q <= PH_FLOAT;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            PH_FLOAT: begin
               if (tick_i) begin
                  if (cnt_q == UNIT_LAST) begin
                     phase_q <= PH_SENSE;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            PH_SENSE: begin
               if (tick_i) begin
                  if (cnt_q == SENSE_LAST) begin
                     phase_q <= PH_IDLE;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               phase_q <= PH_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   // Strobe slot position and slot parity: taken from the phase counter
   // when the period is a power of two, otherwise counted separately.
   generate
      if (is_pow2(STROBE_PERIOD)) begin : g_slot_bits
         assign strobe_o   = (phase_q == PH_SENSE) && (cnt_q[SLOT_W-1:0] == '0);
         assign slot_odd_o = cnt_q[SLOT_W];
      end else begin : g_slot_cnt
         localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(STROBE_PERIOD - 1);
         logic [SLOT_W-1:0] slot_q;
         logic              odd_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni || (phase_q != PH_SENSE)) begin
               slot_q <= '0;
               odd_q  <= 1'b0;
            end else if (tick_i) begin
               if (slot_q == SLOT_LAST) begin
                  slot_q <= '0;
                  odd_q  <= ~odd_q;
               end else begin
                  slot_q <= slot_q + 1'b1;
               end
            end
         end
         assign strobe_o   = (phase_q == PH_SENSE) && (slot_q == '0);
         assign slot_odd_o = odd_q;
      end
   endgenerate

endmodule

// File: rtl/bemf_step_judge.sv
module bemf_step_judge
   import bemf_pkg::*;
#(
   parameter int unsigned UNIT_TICKS       = 16,
   parameter int unsigned LIMIT_BASE_UNITS = 4,
   parameter int unsigned CODE_W           = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              tick_i,
   input  logic              eval_i,
   input  logic              pos_i,
   input  logic              neg_i,
   output logic              ok_o
);

   localparam int unsigned LIM_MAX = (LIMIT_BASE_UNITS + (1 << CODE_W) - 1) * UNIT_TICKS;
   localparam int unsigned LIM_W   = $clog2(LIM_MAX + 1);

   logic [LIM_W-1:0] units;
   logic [LIM_W-1:0] limit;
   logic [LIM_W-1:0] cnt_q;
   logic             armed_q;
   logic             ok_q;
   logic             hit;
   logic             expire;

   assign units = LIM_W'(LIMIT_BASE_UNITS) + LIM_W'(code_i);

   generate
      if (is_pow2(UNIT_TICKS)) begin : g_lim_shift
         localparam int unsigned UNIT_SH = $clog2(UNIT_TICKS);
         assign limit = units << UNIT_SH;
      end else begin : g_lim_mult
         assign limit = LIM_W'(units * LIM_W'(UNIT_TICKS));
      end
   endgenerate

   assign hit    = tick_i && eval_i && armed_q && neg_i && (cnt_q < limit);
   assign expire = armed_q && (cnt_q == (limit - 1'b1));
   assign ok_o   = ok_q || hit;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clear_i) begin
         armed_q <= 1'b0;
         ok_q    <= 1'b0;
         cnt_q   <= '0;
      end else if (tick_i) begin
         if (hit) begin
            ok_q <= 1'b1;
         end
         if (armed_q) begin
            if (expire) begin
               if (eval_i && pos_i) begin
                  cnt_q <= '0;
               end else begin
                  armed_q <= 1'b0;
               end
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (eval_i && pos_i) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
         end
      end
   end

endmodule

// File: rtl/bemf_switch_map.sv
module bemf_switch_map
   import bemf_pkg::*;
(
   input  bemf_phase_e phase_i,
   input  logic        strobe_i,
   input  logic        slot_odd_i,
   input  logic        dir_i,
   output logic        hs_a_o,
   output logic        hs_b_o,
   output logic        ls_a_o,
   output logic        ls_b_o,
   output logic        sns_a_o,
   output logic        sns_b_o
);

   logic pair_b;

   assign pair_b = slot_odd_i ^ dir_i;
   assign ls_a_o = 1'b0;
   assign ls_b_o = 1'b0;

   always_comb begin
      hs_a_o  = 1'b0;
      hs_b_o  = 1'b0;
      sns_a_o = 1'b0;
      sns_b_o = 1'b0;
      unique case (phase_i)
         PH_SHORT: begin
            hs_a_o = 1'b1;
            hs_b_o = 1'b1;
         end
         PH_SENSE: begin
            if (!strobe_i) begin
               hs_a_o = 1'b1;
               hs_b_o = 1'b1;
            end else if (pair_b) begin
               hs_a_o  = 1'b1;
               sns_b_o = 1'b1;
            end else begin
               hs_b_o  = 1'b1;
               sns_a_o = 1'b1;
            end
         end
         default: begin
         end
      endcase
   end

endmodule

// File: rtl/bemf_step_sequencer.sv
module bemf_step_sequencer
   import bemf_pkg::*;
#(
   parameter int unsigned UNIT_TICKS       = 16,
   parameter int unsigned STROBE_PERIOD    = 8,
   parameter int unsigned WINDOW_TICKS     = 448,
   parameter int unsigned LIMIT_BASE_UNITS = 4
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  logic       dir_i,
   input  logic       start_i,
   input  logic [2:0] limit_code_i,
   input  logic       cmp_pos_i,
   input  logic       cmp_neg_i,
   output logic       hs_a_o,
   output logic       hs_b_o,
   output logic       ls_a_o,
   output logic       ls_b_o,
   output logic       sns_a_o,
   output logic       sns_b_o,
   output logic       strobe_o,
   output logic       done_o,
   output logic       pass_o
);

   localparam int unsigned CODE_W = 3;

   generate
      if (UNIT_TICKS < 2) begin : g_bad_unit
         $error("UNIT_TICKS must be at least 2");
      end
      if (STROBE_PERIOD < 2) begin : g_bad_period
         $error("STROBE_PERIOD must be at least 2");
      end
      if (WINDOW_TICKS < 2 * UNIT_TICKS + 2 * STROBE_PERIOD) begin : g_bad_window
         $error("WINDOW_TICKS leaves no room for two sample slots");
      end
      if (LIMIT_BASE_UNITS < 1) begin : g_bad_limit
         $error("LIMIT_BASE_UNITS must be at least 1");
      end
   endgenerate

   bemf_phase_e       phase;
   logic              strobe;
   logic              slot_odd;
   logic              accept;
   logic              last;
   logic              ok;
   logic              sensing;
   logic              dir_q;
   logic [CODE_W-1:0] code_q;
   logic              done_q;
   logic              pass_q;

   assign sensing = (phase == PH_SENSE);

   bemf_phase_timer #(
      .UNIT_TICKS    (UNIT_TICKS),
      .STROBE_PERIOD (STROBE_PERIOD),
      .WINDOW_TICKS  (WINDOW_TICKS)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .start_i    (start_i),
      .phase_o    (phase),
      .strobe_o   (strobe),
      .slot_odd_o (slot_odd),
      .accept_o   (accept),
      .last_o     (last)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         dir_q  <= 1'b0;
         code_q <= '0;
      end else if (accept) begin
         dir_q  <= dir_i;
         code_q <= limit_code_i;
      end
   end

   bemf_step_judge #(
      .UNIT_TICKS       (UNIT_TICKS),
      .LIMIT_BASE_UNITS (LIMIT_BASE_UNITS),
      .CODE_W           (CODE_W)
   ) u_judge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (accept),
      .code_i  (code_q),
      .tick_i  (tick_i && sensing),
      .eval_i  (strobe),
      .pos_i   (cmp_pos_i),
      .neg_i   (cmp_neg_i),
      .ok_o    (ok)
   );

   bemf_switch_map u_map (
      .phase_i    (phase),
      .strobe_i   (strobe),
      .slot_odd_i (slot_odd),
      .dir_i      (dir_q),
      .hs_a_o     (hs_a_o),
      .hs_b_o     (hs_b_o),
      .ls_a_o     (ls_a_o),
      .ls_b_o     (ls_b_o),
      .sns_a_o    (sns_a_o),
      .sns_b_o    (sns_b_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         done_q <= 1'b0;
         pass_q <= 1'b0;
      end else begin
         done_q <= last;
         if (last) begin
            pass_q <= ok;
         end
      end
   end

   assign strobe_o = strobe;
   assign done_o   = done_q;
   assign pass_o   = pass_q;

endmodule

// File: rtl/bemf_step_sequencer_chk.sv
module bemf_step_sequencer_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic hs_a_o,
   input logic hs_b_o,
   input logic ls_a_o,
   input logic ls_b_o,
   input logic sns_a_o,
   input logic sns_b_o,
   input logic strobe_o,
   input logic done_o,
   input logic pass_o
);

   AST_SENSE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sns_a_o && sns_b_o)); // R5

   AST_SENSE_A_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sns_a_o |-> (hs_b_o && !hs_a_o && !ls_a_o && !ls_b_o)); // R5

   AST_SENSE_B_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sns_b_o |-> (hs_a_o && !hs_b_o && !ls_a_o && !ls_b_o)); // R5

   AST_SENSE_UNDER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sns_a_o || sns_b_o) |-> strobe_o); // R4

   AST_STROBE_HAS_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strobe_o |-> $onehot0({sns_a_o, sns_b_o}) && (sns_a_o || sns_b_o)); // R4

   AST_SHORT_NO_SENSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hs_a_o && hs_b_o) |-> !(sns_a_o || sns_b_o)); // R2

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R8

   AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |=> (done_o || $stable(pass_o))); // R8

endmodule

bind bemf_step_sequencer bemf_step_sequencer_chk u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .hs_a_o   (hs_a_o),
   .hs_b_o   (hs_b_o),
   .ls_a_o   (ls_a_o),
   .ls_b_o   (ls_b_o),
   .sns_a_o  (sns_a_o),
   .sns_b_o  (sns_b_o),
   .strobe_o (strobe_o),
   .done_o   (done_o),
   .pass_o   (pass_o)
);

// File: tb/bemf_step_sequencer_tb.sv
module bemf_step_sequencer_tb;

   localparam int UNIT  = 16;
   localparam int SP    = 8;
   localparam int WIN   = 448;
   localparam int BASE  = 4;
   localparam int SENSE = WIN - 2 * UNIT;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       dir = 1'b0;
   logic       start = 1'b0;
   logic [2:0] code = 3'd0;
   logic       pos = 1'b0;
   logic       neg = 1'b0;
   logic       hs_a, hs_b, ls_a, ls_b, sns_a, sns_b, strobe, done, pass;

   bemf_step_sequencer u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .tick_i       (tick),
      .dir_i        (dir),
      .start_i      (start),
      .limit_code_i (code),
      .cmp_pos_i    (pos),
      .cmp_neg_i    (neg),
      .hs_a_o       (hs_a),
      .hs_b_o       (hs_b),
      .ls_a_o       (ls_a),
      .ls_b_o       (ls_b),
      .sns_a_o      (sns_a),
      .sns_b_o      (sns_b),
      .strobe_o     (strobe),
      .done_o       (done),
      .pass_o       (pass)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int fails  = 0;

   // behavioural reference model
   int m_ph = 0, m_t = 0, m_dir = 0, m_lim = 0, m_since = 0;
   bit m_armed = 0, m_ok = 0, m_done = 0, m_pass = 0;
   bit m_stb;
   int p0 = -1, p1 = -1, p2 = -1, n0 = -1, n1 = -1, n2 = -1;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_t = 0; m_dir = 0; m_lim = 0; m_since = 0;
         m_armed = 0; m_ok = 0; m_done = 0; m_pass = 0;
      end else begin
         m_done = 0;
         case (m_ph)
            0: if (start) begin
               m_ph = 1; m_t = 0; m_dir = int'(dir);
               m_lim = (BASE + int'(code)) * UNIT;
               m_armed = 0; m_ok = 0; m_since = 0;
            end
            1, 2: if (tick) begin
               m_t++;
               if (m_t == UNIT) begin m_ph++; m_t = 0; end
            end
            3: if (tick) begin
               m_stb = (m_t % SP) == 0;
               if (m_armed) m_since++;
               if (m_stb && m_armed && neg && m_since <= m_lim) m_ok = 1;
               if (m_armed && m_since == m_lim) m_armed = 0;
               if (!m_armed && m_stb && pos) begin m_armed = 1; m_since = 0; end
               m_t++;
               if (m_t == SENSE) begin m_ph = 0; m_t = 0; m_done = 1; m_pass = m_ok; end
            end
            default: m_ph = 0;
         endcase
      end
   end

   function automatic bit in3(int a, int b, int c, int v);
      return (v == a) || (v == b) || (v == c);
   endfunction

   task automatic chk(logic act, logic exp, string req, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   initial forever begin
      @(negedge clk);
      if (rst_n) begin
         bit e_ha, e_hb, e_sa, e_sb, e_st;
         string rq;
         e_ha = 0; e_hb = 0; e_sa = 0; e_sb = 0; e_st = 0;
         if (m_ph == 1) begin e_ha = 1; e_hb = 1; end
         if (m_ph == 3) begin
            e_st = (m_t % SP) == 0;
            if (!e_st) begin e_ha = 1; e_hb = 1; end
            else if ((((m_t / SP) % 2) ^ m_dir) != 0) begin e_ha = 1; e_sb = 1; end
            else begin e_hb = 1; e_sa = 1; end
         end
         rq = (m_ph == 1) ? "R2" : (m_ph == 2) ? "R3" : (m_ph == 3) ? "R5" : "R1";
         chk(hs_a, e_ha, rq, "hs_a");
         chk(hs_b, e_hb, rq, "hs_b");
         chk(sns_a, e_sa, rq, "sns_a");
         chk(sns_b, e_sb, rq, "sns_b");
         chk(strobe, e_st, "R4", "strobe");
         chk(ls_a, 1'b0, "R9", "ls_a");
         chk(ls_b, 1'b0, "R9", "ls_b");
         chk(done, m_done, "R8", "done");
         chk(pass, m_pass, "R6", "pass");
      end
   end

   // tick every second clock
   initial forever begin
      @(negedge clk);
      tick = ~tick;
   end

   // comparator stimulus keyed to the strobe index of the model
   initial forever begin
      @(negedge clk);
      if (m_ph == 3 && (m_t % SP) == 0) begin
         pos = in3(p0, p1, p2, m_t / SP);
         neg = in3(n0, n1, n2, m_t / SP);
      end else begin
         pos = 1'b0;
         neg = 1'b0;
      end
   end

   task automatic run_window(bit d, int c, int a0, int a1, int a2, int b0, int b1, int b2,
                             bit exp_pass, string req, bit poke);
      p0 = a0; p1 = a1; p2 = a2; n0 = b0; n1 = b1; n2 = b2;
      @(negedge clk);
      dir = d; code = 3'(c); start = 1'b1;
      @(negedge clk);
      start = 1'b0; dir = ~d; code = 3'(7 - c);
      if (poke) begin
         while (m_ph != 3) @(negedge clk);
         repeat (20) @(negedge clk);
         start = 1'b1; dir = ~d; code = 3'd7;
         @(negedge clk);
         start = 1'b0;
      end
      while (done !== 1'b1) @(negedge clk);
      chk(pass, exp_pass, req, "window result");
      @(negedge clk);
      chk(done, 1'b0, "R8", "done width");
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(hs_a | hs_b | sns_a | sns_b | ls_a | ls_b, 1'b0, "R1", "switches in reset");
      chk(strobe | done | pass, 1'b0, "R1", "strobe/done/pass in reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(hs_a | hs_b | sns_a | sns_b, 1'b0, "R1", "idle switches");
      // R6: negative exactly at the limit (code 0, 64 ticks = 8 strobes)
      run_window(1'b0, 0, 2, -1, -1, 10, -1, -1, 1'b1, "R6", 1'b0);
      // R10: negative one strobe past the limit
      run_window(1'b0, 0, 2, -1, -1, 11, -1, -1, 1'b0, "R10", 1'b0);
      // R6: longest code, reverse direction
      run_window(1'b1, 7, 3, -1, -1, 25, -1, -1, 1'b1, "R6", 1'b0);
      // R7: negative before any positive is ignored
      run_window(1'b1, 2, 4, -1, -1, 1, -1, -1, 1'b0, "R7", 1'b0);
      // R7: positive at the expiry strobe re-arms
      run_window(1'b0, 0, 0, 8, -1, 16, -1, -1, 1'b1, "R7", 1'b0);
      // R7: positive while armed does not restart the timer
      run_window(1'b0, 0, 0, 4, -1, 12, -1, -1, 1'b0, "R7", 1'b0);
      // R10: silent comparators
      run_window(1'b1, 3, -1, -1, -1, -1, -1, -1, 1'b0, "R10", 1'b0);
      // R9 and R8: start ignored mid-window, pair on the last strobes
      run_window(1'b1, 0, 45, -1, -1, 51, -1, -1, 1'b1, "R9", 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule